// File: doc/BRIEF.md
# Oversampled Multichannel Input Capture Buffer

The block samples the logic level of several digital input lines many times per slow cycle and delivers each cycle's samples as one packed image. Each raw line first crosses a two-stage synchroniser; nothing filters it, so a level that lasts a single clock still reaches the sample point. Every pulse on the fast sample strobe stores one bit per channel into a fill buffer, at the next free position.

A pulse on the slow cycle strobe moves the completed fill image into a read register that the consumer sees, and the fill buffer starts empty. The number of samples per channel in a cycle is the oversampling factor `n` (1 to `MAX_N`). A factor outside that range counts as 1, so only the first bit of each channel field carries data.

The valid flag stays low until a fixed number of cycle strobes after reset, so the consumer ignores start-up frames. A cycle that closes with fewer than `n` samples sets a sticky underrun flag once the hold-off has passed.

Top module: `osmp_capture`

## Requirements
- R1: A raw input level reaches the sampler after two clock edges. The bench drives a level at a falling edge and pulses the sample strobe two falling edges later, and that sample records the level. A level held for only one clock is therefore captured.
- R2: Each accepted sample stores bit `c` of the synchronised input into channel `c`'s field, bits `[c*MAX_N +: MAX_N]` of the frame. The k-th sample of a cycle (k from 0) goes to field bit k.
- R3: Sample strobes beyond `n` in one cycle are ignored and leave the frame unchanged.
- R4: An oversampling factor of 0 or above `MAX_N` is treated as 1: only field bit 0 is written, and one sample makes a full frame.
- R5: `frame_out` changes only on the clock edge where `cycle_stb` is high. It then shows the image filled since the previous cycle strobe, and fill bits that were never written read 0.
- R6: A cycle strobe that arrives with fewer than `n` samples taken sets `underrun` to 1 and keeps it at 1 until reset. This applies only after the hold-off. During the hold-off a short frame leaves it at 0.
- R7: `frame_valid` is 0 for the frames latched by the first `HOLDOFF` cycle strobes after reset. It goes to 1 on the next cycle strobe and stays at 1.
- R8: During reset and before any strobe, `frame_out` is 0, and `frame_valid` and `underrun` are 0.
- R9: A sample strobe in the same cycle as a cycle strobe belongs to the new frame as its sample 0. It is not part of the frame being latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| din | input | NCH | Raw channel levels, asynchronous |
| sample_stb | input | 1 | Fast sample strobe, one clock wide |
| cycle_stb | input | 1 | Slow cycle strobe, one clock wide |
| os_factor | input | FW | Oversampling factor, FW = clog2(MAX_N+1) |
| frame_out | output | NCH*MAX_N | Packed read image of the last completed cycle |
| frame_valid | output | 1 | Read image is past the start-up hold-off |
| underrun | output | 1 | Sticky: a cycle closed with too few samples |

## Verification
A wrong fill index shows up in the next latched frame: bits land shifted, samples beyond `n` overwrite data, or a coincident sample lands in the closing frame. Each of these is visible one clock after the cycle strobe. A broken hold-off counter raises `frame_valid` one or more strobes early or late, and a wrong short-frame test flips `underrun` at the strobe that closes the frame. A read register that follows the fill buffer shows up as `frame_out` moving between strobes, in the same clock as the sample that changed it.

// File: rtl/osmp_pkg.sv
package osmp_pkg;
  // effective factor: out-of-range requests collapse to one sample
  function automatic int unsigned clamp_factor(int unsigned raw, int unsigned max_n);
    return (raw == 0 || raw > max_n) ? 1 : raw;
  endfunction

  // a frame is short when fewer samples were stored than needed
  function automatic bit frame_short(int unsigned filled, int unsigned need);
    return filled < need;
  endfunction
endpackage

// File: rtl/osmp_sync.sv
module osmp_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end
endmodule

// File: rtl/osmp_ctrl.sv
module osmp_ctrl #(
  parameter int MAX_N   = 1000,
  parameter int HOLDOFF = 60,
  localparam int FW = $clog2(MAX_N + 1),
  localparam int HW = $clog2(HOLDOFF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic          cycle_stb,
  input  logic [FW-1:0] os_factor,
  output logic          wr_en,
  output logic [FW-1:0] wr_pos,
  output logic [FW-1:0] fill_idx,
  output logic [FW-1:0] n_eff,
  output logic          frame_valid,
  output logic          underrun
);
  import osmp_pkg::*;

  logic [HW-1:0] strobe_cnt;
  logic          live;
  logic          short_now;

  assign n_eff     = FW'(clamp_factor(32'(os_factor), MAX_N));
  assign live      = (strobe_cnt == HW'(HOLDOFF));
  assign short_now = frame_short(32'(fill_idx), 32'(n_eff));
  assign wr_en     = sample_stb && (cycle_stb || (fill_idx < n_eff));
  assign wr_pos    = cycle_stb ? '0 : fill_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_idx <= '0;
    end else if (cycle_stb) begin
      fill_idx <= sample_stb ? FW'(1) : '0;
    end else if (wr_en) begin
      fill_idx <= fill_idx + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_cnt  <= '0;
      frame_valid <= 1'b0;
      underrun    <= 1'b0;
    end else if (cycle_stb) begin
      if (!live) strobe_cnt <= strobe_cnt + HW'(1);
      if (live) frame_valid <= 1'b1;
      if (live && short_now) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/osmp_frame_buf.sv
module osmp_frame_buf #(
  parameter int NCH   = 2,
  parameter int MAX_N = 1000,
  localparam int FW = $clog2(MAX_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     bits,
  input  logic               wr_en,
  input  logic [FW-1:0]      wr_pos,
  input  logic               cycle_stb,
  output logic [NCH*MAX_N-1:0] frame_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [MAX_N-1:0] fill;
    logic [MAX_N-1:0] rd;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fill <= '0;
        rd   <= '0;
      end else begin
        if (cycle_stb) begin
          rd   <= fill;
          fill <= '0;
          if (wr_en) fill[0] <= bits[c];
        end else if (wr_en) begin
          for (int k = 0; k < MAX_N; k++) begin
            if (wr_pos == FW'(k)) fill[k] <= bits[c];
          end
        end
      end
    end

    assign frame_out[c*MAX_N +: MAX_N] = rd;
  end
endmodule

// File: rtl/osmp_capture.sv
module osmp_capture #(
  parameter int NCH     = 2,
  parameter int MAX_N   = 1000,
  parameter int HOLDOFF = 60,
  localparam int FW = $clog2(MAX_N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       din,
  input  logic                 sample_stb,
  input  logic                 cycle_stb,
  input  logic [FW-1:0]        os_factor,
  output logic [NCH*MAX_N-1:0] frame_out,
  output logic                 frame_valid,
  output logic                 underrun
);
  logic [NCH-1:0] din_s;
  logic           smp_wr;
  logic [FW-1:0]  wr_pos;
  logic [FW-1:0]  fill_idx;
  logic [FW-1:0]  n_eff;

  osmp_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(din), .synced(din_s)
  );

  osmp_ctrl #(.MAX_N(MAX_N), .HOLDOFF(HOLDOFF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .cycle_stb(cycle_stb),
    .os_factor(os_factor), .wr_en(smp_wr), .wr_pos(wr_pos), .fill_idx(fill_idx),
    .n_eff(n_eff), .frame_valid(frame_valid), .underrun(underrun)
  );

  osmp_frame_buf #(.NCH(NCH), .MAX_N(MAX_N)) u_buf (
    .clk(clk), .rst_n(rst_n), .bits(din_s), .wr_en(smp_wr), .wr_pos(wr_pos),
    .cycle_stb(cycle_stb), .frame_out(frame_out)
  );
endmodule

// File: rtl/osmp_capture_chk.sv
module osmp_capture_chk #(
  parameter int NCH   = 2,
  parameter int MAX_N = 1000,
  localparam int FW = $clog2(MAX_N + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cycle_stb,
  input logic [NCH*MAX_N-1:0] frame_out,
  input logic                 frame_valid,
  input logic                 underrun,
  input logic [FW-1:0]        fill_idx,
  input logic [FW-1:0]        n_eff
);
  // R5
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_stb |=> $stable(frame_out));

  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> frame_valid);

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> $past(cycle_stb));

  // R6
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_idx <= n_eff);

  // R4
  factor_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_eff >= FW'(1)) && (32'(n_eff) <= MAX_N));
endmodule

bind osmp_capture osmp_capture_chk #(.NCH(NCH), .MAX_N(MAX_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_stb(cycle_stb), .frame_out(frame_out),
  .frame_valid(frame_valid), .underrun(underrun), .fill_idx(fill_idx), .n_eff(n_eff)
);

// File: tb/sim_osmp_capture.sv
module sim_osmp_capture;
  localparam int NCH = 3;
  localparam int MAX_N = 16;
  localparam int HOLDOFF = 4;
  localparam int FW = $clog2(MAX_N + 1);
  localparam int FRW = NCH * MAX_N;

  typedef struct packed {
    logic [FRW-1:0] frame;
    logic           valid;
    logic           urun;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] din = '0;
  logic sample_stb = 0, cycle_stb = 0;
  logic [FW-1:0] os_factor = FW'(4);
  logic [FRW-1:0] frame_out;
  logic frame_valid, underrun;

  osmp_capture #(.NCH(NCH), .MAX_N(MAX_N), .HOLDOFF(HOLDOFF)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .sample_stb(sample_stb),
    .cycle_stb(cycle_stb), .os_factor(os_factor), .frame_out(frame_out),
    .frame_valid(frame_valid), .underrun(underrun)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [FRW-1:0] m_fill = '0, m_last = '0;
  int m_idx = 0, m_strobes = 0;
  bit m_valid = 0, m_urun = 0;
  string cur_req = "R2";
  bit done = 0;

  function automatic int need();
    int f = int'(os_factor);
    if (f >= 1 && f <= MAX_N) return f;
    return 1;
  endfunction

  task automatic check(string req, logic [FRW-1:0] act, logic [FRW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [NCH-1:0] b);
    if (m_idx < need()) begin
      for (int c = 0; c < NCH; c++) m_fill[c*MAX_N + m_idx] = b[c];
      m_idx++;
    end
  endtask

  task automatic model_close();
    exp_t e;
    if (m_strobes >= HOLDOFF) begin
      m_valid = 1;
      if (m_idx < need()) m_urun = 1;
    end else m_strobes++;
    e.frame = m_fill; e.valid = m_valid; e.urun = m_urun;
    q.push_back(e);
    m_last = m_fill;
    m_fill = '0; m_idx = 0;
  endtask

  task automatic sample(logic [NCH-1:0] b);
    din = b;
    @(negedge clk); @(negedge clk);
    sample_stb = 1; model_write(b);
    @(negedge clk); sample_stb = 0;
    // R5: read image unchanged while filling
    check("R5", frame_out, m_last);
  endtask

  task automatic pulse(logic [NCH-1:0] b);
    din = b;
    @(negedge clk); din = '0;
    @(negedge clk);
    sample_stb = 1; model_write(b);
    @(negedge clk); sample_stb = 0;
  endtask

  task automatic close_cycle();
    cycle_stb = 1; model_close();
    @(negedge clk); cycle_stb = 0;
    @(negedge clk);
  endtask

  task automatic coincident(logic [NCH-1:0] b);
    din = b;
    @(negedge clk); @(negedge clk);
    sample_stb = 1; cycle_stb = 1;
    model_close(); model_write(b);
    @(negedge clk); sample_stb = 0; cycle_stb = 0;
    @(negedge clk);
  endtask

  // monitor: compare each latched frame one clock after the cycle strobe
  always @(posedge clk) begin
    if (rst_n && cycle_stb) begin
      exp_t e;
      @(negedge clk);
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL %s actual=unexpected frame expected=none", cur_req);
      end else begin
        e = q.pop_front();
        check(cur_req, frame_out, e.frame);
        check("R7", {{(FRW-1){1'b0}}, frame_valid}, {{(FRW-1){1'b0}}, e.valid});
        check("R6", {{(FRW-1){1'b0}}, underrun}, {{(FRW-1){1'b0}}, e.urun});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", frame_out, '0);
    check("R8", {{(FRW-1){1'b0}}, frame_valid, underrun} , '0);
    rst_n = 1;
    @(negedge clk);
    check("R8", frame_out, '0);

    // hold-off: first frame empty (short, but no underrun during hold-off: R6, R7)
    cur_req = "R7";
    close_cycle();
    for (int f = 0; f < HOLDOFF - 1; f++) begin
      sample(3'b101); sample(3'b010); sample(3'b111); sample(3'b001);
      close_cycle();
    end
    // first valid frame, n = 4 (R2, R7)
    cur_req = "R2";
    sample(3'b110); sample(3'b011); sample(3'b000); sample(3'b100);
    close_cycle();
    // full width n = MAX_N (R2)
    os_factor = FW'(MAX_N);
    for (int k = 0; k < MAX_N; k++) sample(NCH'(k * 5 + 3));
    close_cycle();
    // extra strobes ignored (R3)
    cur_req = "R3";
    os_factor = FW'(3);
    sample(3'b111); sample(3'b010); sample(3'b101); sample(3'b111); sample(3'b111);
    close_cycle();
    // factor 0 -> 1 (R4)
    cur_req = "R4";
    os_factor = '0;
    sample(3'b011); sample(3'b111);
    close_cycle();
    // factor above MAX_N -> 1 (R4)
    os_factor = FW'(MAX_N + 4);
    sample(3'b110);
    close_cycle();
    // single-clock pulse captured after two edges (R1)
    cur_req = "R1";
    os_factor = FW'(1);
    pulse(3'b101);
    close_cycle();
    // coincident sample opens the new frame (R9)
    cur_req = "R9";
    os_factor = FW'(2);
    sample(3'b001); sample(3'b010);
    coincident(3'b100);
    sample(3'b011);
    close_cycle();
    // short frame sets sticky underrun, missing bits zero (R6)
    cur_req = "R6";
    os_factor = FW'(8);
    sample(3'b111); sample(3'b111); sample(3'b001); sample(3'b110); sample(3'b101);
    close_cycle();
    os_factor = FW'(1);
    sample(3'b010);
    close_cycle();

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule